// File: doc/BRIEF.md
# UART Receive Holding Buffer

This block takes characters from a UART receive deserializer and hands them to a 32-bit processor bus. When a character completes, it arrives with its length (5 to 8 data bits) and its parity and framing error indications. The block right-justifies each character and zero-fills it to a byte. It then stores the byte either in one holding register or in a 16-entry first-in first-out queue. A mode input selects which store is used. The read port always presents the oldest unread byte in the low eight bits of the bus word.

The block keeps a data-ready indication. It also keeps three sticky line error flags: parity, framing and overrun. A read of the data port removes one byte and affects only data-ready. The error flags are cleared only by a line-status read strobe. Any change of the mode input discards all stored bytes.

Top module: `uart_rx_buffer`

## Requirements
- R1: After reset, rd_data_o is 0, data_ready_o is 0 and all three error flags are 0.
- R2: char_len_i selects the character length: 0 means 5 bits, 1 means 6, 2 means 7, 3 means 8. The stored byte keeps the low bits of char_bits_i for that length, and its upper bits are zero.
- R3: In single-register mode (fifo_mode_i=0), a data read clears data_ready_o on the following cycle, and rd_data_o then reads 0.
- R4: A data read leaves the parity, framing and overrun flags unchanged.
- R5: In queue mode (fifo_mode_i=1), rd_data_o shows the oldest stored byte, and each data read removes exactly that byte.
- R6: In queue mode, data_ready_o stays 1 as long as at least one byte remains stored.
- R7: In single-register mode, a character that arrives while the register is full and not being read replaces the stored byte and sets the overrun flag.
- R8: In queue mode, the queue holds 16 bytes. A character that arrives while it is full and not being read is discarded and sets the overrun flag.
- R9: rd_lsr_i clears all three error flags on the next cycle. If a new error is reported in the same cycle, that flag is set instead.
- R10: Bits 31:8 of rd_data_o are always 0.
- R11: A change of fifo_mode_i empties both stores, so data_ready_o is 0 on the next cycle. A character that arrives in the cycle of the change is dropped.
- R12: A character that arrives with parity_err_i or frame_err_i set makes the matching flag 1, and the flag stays 1 until it is cleared as in R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fifo_mode_i | input | 1 | 1 selects queue mode, 0 selects single-register mode |
| char_valid_i | input | 1 | One-cycle strobe: a received character is complete |
| char_bits_i | input | 8 | Received bits, first bit in bit 0 |
| char_len_i | input | 2 | Character length code (see R2) |
| parity_err_i | input | 1 | Parity error on this character |
| frame_err_i | input | 1 | Framing error on this character |
| rd_data_i | input | 1 | Bus read of the data port |
| rd_lsr_i | input | 1 | Bus read of the line status |
| rd_data_o | output | 32 | Oldest byte in bits 7:0; bits 31:8 are zero |
| data_ready_o | output | 1 | At least one unread byte is stored |
| parity_err_o | output | 1 | Sticky parity error flag |
| frame_err_o | output | 1 | Sticky framing error flag |
| overrun_err_o | output | 1 | Sticky overrun flag |

## Verification
The hardest state to reach is a completely full queue that receives one more character. This case must show three things: the extra byte is discarded, the overrun flag is set, and all sixteen stored bytes still drain in order. The stimulus reaches it by switching to queue mode and pushing seventeen numbered characters with no reads in between. It then reads the queue back one entry at a time and checks data-ready before each read. A second hard case is a line-status read in the same cycle as a new parity error. The bench places both strobes on the same edge to check that the set takes priority.

// File: rtl/uart_rxb_pkg.sv
package uart_rxb_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned BUS_W  = 32;

  typedef enum logic [1:0] {
    LEN5 = 2'd0,
    LEN6 = 2'd1,
    LEN7 = 2'd2,
    LEN8 = 2'd3
  } char_len_e;
endpackage

// File: rtl/rxb_char_align.sv
module rxb_char_align
  import uart_rxb_pkg::*;
(
  input  logic [DATA_W-1:0] bits_i,
  input  char_len_e         len_i,
  output logic [DATA_W-1:0] byte_o
);
  logic [DATA_W-1:0] mask;

  // keep the low (5 + len) bits
  always_comb begin
    mask   = {DATA_W{1'b1}} >> (2'd3 - len_i);
    byte_o = bits_i & mask;
  end

  always_comb begin
    if (len_i == LEN5) assert_len5_R2: assert (byte_o[DATA_W-1:5] == '0);
  end
endmodule

// File: rtl/rxb_fifo.sv
module rxb_fifo #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned W     = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         flush_i,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] data_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] count_q;
  logic             do_push, do_pop;

  assign empty_o = (count_q == '0);
  assign full_o  = (count_q == FULL_CNT);
  assign data_o  = mem_q[rd_ptr_q];
  assign do_pop  = pop_i & ~empty_o;
  assign do_push = push_i & (~full_o | do_pop);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else if (flush_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (do_push) wr_ptr_q <= (wr_ptr_q == LAST) ? '0 : wr_ptr_q + 1'b1;
      if (do_pop)  rd_ptr_q <= (rd_ptr_q == LAST) ? '0 : rd_ptr_q + 1'b1;
      if (do_push && !do_pop)      count_q <= count_q + 1'b1;
      else if (do_pop && !do_push) count_q <= count_q - 1'b1;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mem_q[g] <= '0;
      else if (do_push && !flush_i && wr_ptr_q == PTR_W'(g)) mem_q[g] <= data_i;
    end
  end

  assert_no_overflow_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && push_i && !pop_i && !flush_i |=> full_o && count_q == $past(count_q));
  assert_pop_order_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    do_pop && !flush_i |=> rd_ptr_q != $past(rd_ptr_q) || DEPTH == 1);
  assert_count_range_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= FULL_CNT);
endmodule

// File: rtl/rxb_line_flags.sv
module rxb_line_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic set_pe_i,
  input  logic set_fe_i,
  input  logic set_oe_i,
  output logic pe_o,
  output logic fe_o,
  output logic oe_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pe_o <= 1'b0;
      fe_o <= 1'b0;
      oe_o <= 1'b0;
    end else begin
      // set beats clear
      pe_o <= set_pe_i | (pe_o & ~clr_i);
      fe_o <= set_fe_i | (fe_o & ~clr_i);
      oe_o <= set_oe_i | (oe_o & ~clr_i);
    end
  end

  assert_sticky_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pe_o && !clr_i |=> pe_o);
  assert_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && !set_pe_i && !set_fe_i && !set_oe_i |=> !pe_o && !fe_o && !oe_o);
  assert_set_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_pe_i |=> pe_o);
endmodule

// File: rtl/uart_rx_buffer.sv
module uart_rx_buffer
  import uart_rxb_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fifo_mode_i,
  input  logic              char_valid_i,
  input  logic [DATA_W-1:0] char_bits_i,
  input  logic [1:0]        char_len_i,
  input  logic              parity_err_i,
  input  logic              frame_err_i,
  input  logic              rd_data_i,
  input  logic              rd_lsr_i,
  output logic [BUS_W-1:0]  rd_data_o,
  output logic              data_ready_o,
  output logic              parity_err_o,
  output logic              frame_err_o,
  output logic              overrun_err_o
);
  logic              mode_q, mode_chg, push;
  logic [DATA_W-1:0] aligned, fifo_data, hold_q, head;
  logic              hold_vld_q, fifo_empty, fifo_full, overrun;

  assign mode_chg = fifo_mode_i ^ mode_q;
  assign push     = char_valid_i & ~mode_chg;

  rxb_char_align u_align (
    .bits_i (char_bits_i),
    .len_i  (char_len_e'(char_len_i)),
    .byte_o (aligned)
  );

  rxb_fifo #(.DEPTH(FIFO_DEPTH), .W(DATA_W)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (mode_chg),
    .push_i  (push & mode_q),
    .pop_i   (rd_data_i & mode_q & ~mode_chg),
    .data_i  (aligned),
    .data_o  (fifo_data),
    .empty_o (fifo_empty),
    .full_o  (fifo_full)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q     <= 1'b0;
      hold_q     <= '0;
      hold_vld_q <= 1'b0;
    end else begin
      mode_q <= fifo_mode_i;
      if (mode_chg) begin
        hold_q     <= '0;
        hold_vld_q <= 1'b0;
      end else if (!mode_q) begin
        if (push) begin
          hold_q     <= aligned;
          hold_vld_q <= 1'b1;
        end else if (rd_data_i) begin
          hold_q     <= '0;
          hold_vld_q <= 1'b0;
        end
      end
    end
  end

  assign overrun = push & ~rd_data_i & (mode_q ? fifo_full : hold_vld_q);

  rxb_line_flags u_flags (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (rd_lsr_i),
    .set_pe_i (char_valid_i & parity_err_i),
    .set_fe_i (char_valid_i & frame_err_i),
    .set_oe_i (overrun),
    .pe_o     (parity_err_o),
    .fe_o     (frame_err_o),
    .oe_o     (overrun_err_o)
  );

  assign data_ready_o = mode_q ? ~fifo_empty : hold_vld_q;
  assign head         = mode_q ? (fifo_empty ? '0 : fifo_data) : hold_q;
  assign rd_data_o    = {{(BUS_W-DATA_W){1'b0}}, head};

  assert_dr_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_q && !mode_chg && rd_data_i && !char_valid_i |=> !data_ready_o && rd_data_o == '0);
  assert_flush_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_chg |=> !data_ready_o);
  assert_hold_ovr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_q && !mode_chg && hold_vld_q && char_valid_i && !rd_data_i |=> overrun_err_o);
  assert_flags_kept_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_i && !rd_lsr_i && frame_err_o |=> frame_err_o);
endmodule

// File: tb/test_uart_rx_buffer.sv
module test_uart_rx_buffer;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fifo_mode = 1'b0, cval = 1'b0, pe = 1'b0, fe = 1'b0;
  logic        rd = 1'b0, lsr = 1'b0;
  logic [7:0]  cbits = '0;
  logic [1:0]  clen = '0;
  logic [31:0] rdata;
  logic        dr, pe_o, fe_o, oe_o;
  int          errors = 0, checks = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_rx_buffer i_uart_rx_buffer (
    .clk_i(clk), .rst_ni(rst_n), .fifo_mode_i(fifo_mode),
    .char_valid_i(cval), .char_bits_i(cbits), .char_len_i(clen),
    .parity_err_i(pe), .frame_err_i(fe), .rd_data_i(rd), .rd_lsr_i(lsr),
    .rd_data_o(rdata), .data_ready_o(dr), .parity_err_o(pe_o),
    .frame_err_o(fe_o), .overrun_err_o(oe_o)
  );

  // {len, raw bits, expected byte}
  localparam logic [17:0] VEC [8] = '{
    {2'd0, 8'hFF, 8'h1F}, {2'd1, 8'hFF, 8'h3F},
    {2'd2, 8'hFF, 8'h7F}, {2'd3, 8'hFF, 8'hFF},
    {2'd0, 8'hA5, 8'h05}, {2'd1, 8'hC3, 8'h03},
    {2'd2, 8'h81, 8'h01}, {2'd3, 8'h5A, 8'h5A}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push(logic [1:0] len, logic [7:0] b, logic p, logic f);
    @(negedge clk);
    cval = 1'b1; clen = len; cbits = b; pe = p; fe = f;
    @(negedge clk);
    cval = 1'b0; pe = 1'b0; fe = 1'b0;
  endtask

  task automatic read_data();
    @(negedge clk); rd = 1'b1;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic read_lsr();
    @(negedge clk); lsr = 1'b1;
    @(negedge clk); lsr = 1'b0;
  endtask

  task automatic set_mode(logic m);
    @(negedge clk); fifo_mode = m;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 data", rdata, 32'h0);
    check("R1 flags", {dr, pe_o, fe_o, oe_o}, 4'b0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 / R10 / R3 table walk, single-register mode
    for (int i = 0; i < 8; i++) begin
      push(VEC[i][17:16], VEC[i][15:8], 1'b0, 1'b0);
      check("R2 aligned byte", rdata, {24'h0, VEC[i][7:0]});
      check("R10 upper zero", {8'h0, rdata[31:8]}, 32'h0);
      check("R3 ready set", dr, 1'b1);
      read_data();
      check("R3 ready cleared", dr, 1'b0);
      check("R3 data emptied", rdata, 32'h0);
    end

    // R12 / R4: errors sticky across a data read
    push(2'd3, 8'h11, 1'b1, 1'b1);
    check("R12 parity set", pe_o, 1'b1);
    check("R12 framing set", fe_o, 1'b1);
    read_data();
    check("R4 flags kept after read", {pe_o, fe_o}, 2'b11);
    check("R4 ready cleared", dr, 1'b0);

    // R9 clear
    read_lsr();
    check("R9 flags cleared", {pe_o, fe_o, oe_o}, 3'b0);

    // R7 overwrite in single-register mode
    push(2'd3, 8'h22, 1'b0, 1'b0);
    push(2'd3, 8'h33, 1'b0, 1'b0);
    check("R7 overwritten", rdata, 32'h33);
    check("R7 overrun", oe_o, 1'b1);
    read_data();
    check("R4 overrun kept", oe_o, 1'b1);

    // R9 set wins over clear
    @(negedge clk);
    lsr = 1'b1; cval = 1'b1; cbits = 8'h44; clen = 2'd3; pe = 1'b1;
    @(negedge clk);
    lsr = 1'b0; cval = 1'b0; pe = 1'b0;
    check("R9 set wins", pe_o, 1'b1);
    check("R9 others cleared", oe_o, 1'b0);
    read_data();
    read_lsr();

    // R11 mode switch flushes single register
    push(2'd3, 8'h55, 1'b0, 1'b0);
    set_mode(1'b1);
    check("R11 flushed ready", dr, 1'b0);
    check("R11 flushed data", rdata, 32'h0);

    // R8 fill queue, overflow once
    for (int i = 1; i <= 17; i++) push(2'd3, 8'(i), 1'b0, 1'b0);
    check("R8 overrun on full", oe_o, 1'b1);
    for (int i = 1; i <= 16; i++) begin
      check("R6 ready while stored", dr, 1'b1);
      check("R5 oldest first", rdata, 32'(i));
      read_data();
    end
    check("R8 extra byte discarded", dr, 1'b0);
    check("R5 empty data", rdata, 32'h0);
    read_lsr();

    // R11 queue flush on switch back
    push(2'd0, 8'hE3, 1'b0, 1'b0);
    push(2'd1, 8'hC7, 1'b0, 1'b0);
    check("R2 queue aligned", rdata, 32'h03);
    set_mode(1'b0);
    check("R11 queue flushed", dr, 1'b0);
    check("R11 no overrun", oe_o, 1'b0);

    // R11 char in switch cycle dropped
    @(negedge clk);
    fifo_mode = 1'b1; cval = 1'b1; cbits = 8'h77; clen = 2'd3;
    @(negedge clk);
    cval = 1'b0;
    check("R11 switch-cycle char dropped", dr, 1'b0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule